// File: doc/BRIEF.md
# Boot-Block Flash Command Interpreter

This block sits between the parallel bus of a NOR-style flash device and its storage array. It sees bus write cycles as command bytes. It runs the two-step program and erase sequences and hands each accepted operation to an array model as a one-cycle request carrying the address, data and block number. It also picks what a bus read returns: array contents, the status word or the identifier codes.

The array is split into eleven erase blocks of unequal size: one boot block, two parameter blocks, one three-quarter-size main block and seven full main blocks. The boot block sits at the highest or lowest addresses, set by the `TOP_BOOT` parameter. The boot block cannot be changed unless the write-protect pin is high or the high-voltage unlock flag is set. Any program or erase also needs the program supply to be valid. An operation that fails these checks is refused: it gets a status error and the array sees no request.

Top module: `bootflash_cmd`

## Requirements
- R1: While `rpN` is low, `dataOe` is low, the status error bits are cleared, the read mode returns to array and the sequencer is idle. Writes made while `rpN` is low have no effect once `rpN` rises.
- R2: `dataOe` is high only when `rpN` is high, `ceN` is low, `oeN` is low and `weN` is high.
- R3: A write cycle is the first clock with `ceN` and `weN` both low. Command FFh selects array reads (`dataOut` = `arrRdData`), 90h selects identifier reads and 70h selects status reads. Any other byte written while idle changes nothing.
- R4: In identifier mode, address bit 0 low returns 0089h. Address bit 0 high returns 889Ch when `TOP_BOOT`=1, or 889Dh when `TOP_BOOT`=0.
- R5: The status word has ready at bit 7, erase-fail at bit 5, program-fail at bit 4, supply-low at bit 3, boot-lock at bit 1, and zeros elsewhere. Ready is 0 only while an operation is busy.
- R6: An erase starts only when 20h is followed by D0h. Any other second byte starts no erase, sets both the erase-fail and program-fail bits, and returns to idle.
- R7: 10h or 40h arms a program. The next write cycle issues `arrProgReq` for one clock with that cycle's address on `arrAddr` and its data on `arrData`.
- R8: A program or erase aimed at the boot block is refused when `wpN` and `hvUnlock` are both low. The refusal sets boot-lock and the operation's fail bit. Other blocks ignore both pins.
- R9: A program or erase confirmed while `supplyOk` is low is refused and sets supply-low and the operation's fail bit. This check comes before the boot-lock check.
- R10: If `supplyOk` falls at any clock while an operation is busy, supply-low and the operation's fail bit are set when `arrDone` arrives.
- R11: While busy, write cycles are ignored and reads return the status word. The operation ends on the clock where `arrDone` is high.
- R12: `arrBlock` numbers the blocks 0 to 10 from the lowest address up. With `TOP_BOOT`=1 the blocks are: seven full blocks of 64K words at 0, then a 48K-word block (7), parameter blocks at 7C000h (8) and 7D000h (9), and the boot block at 7E000h (10).
- R13: Command 50h clears all error bits and leaves the read mode unchanged.
- R14: Any setup, confirm or refusal switches reads to status mode. Reads stay in status mode until FFh is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rpN | input | 1 | Reset/power-down, active low, asynchronous |
| hvUnlock | input | 1 | Reset pin held at unlock voltage; opens the boot block |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| wpN | input | 1 | Write-protect; high opens the boot block |
| supplyOk | input | 1 | Program supply valid |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Bus write data; low byte is the command |
| dataOut | output | DATA_W | Read data for the selected mode |
| dataOe | output | 1 | Output drive enable |
| arrRdData | input | DATA_W | Array word at `addr` from the array model |
| arrDone | input | 1 | Array model finished the busy operation |
| arrProgReq | output | 1 | One-cycle program request |
| arrEraseReq | output | 1 | One-cycle erase request |
| arrAddr | output | ADDR_W | Address captured with a request |
| arrData | output | DATA_W | Program data captured with a request |
| arrBlock | output | 4 | Block index of the request |

## Verification
The assertions assume that `arrDone` arrives only while an operation is busy. They also assume `rpN` changes only when no write cycle is open, so that releasing reset cannot create a write edge. The bench pulses `arrDone` only after it has seen a request. It closes every bus cycle and raises `weN` before it raises `rpN`. The bench also holds `ceN` and `weN` low for exactly one rising edge per write, so each write gives exactly one command.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  localparam int BLK_W   = 4;
  localparam int NUM_BLK = 11;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_PROG_SET_A = 8'h10;
  localparam logic [7:0] CMD_PROG_SET_B = 8'h40;

  localparam int ST_READY = 7;
  localparam int ST_EFAIL = 5;
  localparam int ST_PFAIL = 4;
  localparam int ST_VLOW  = 3;
  localparam int ST_LOCK  = 1;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } readMode_t;

  typedef struct packed {
    logic      modeEn;
    readMode_t mode;
    logic      clrErr;
    logic      failErase;
    logic      failProg;
    logic      flagSupply;
    logic      flagLock;
    logic      issueErase;
    logic      issueProg;
  } ctlStrobe_t;

endpackage

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
(
  input  logic       clk,
  input  logic       rpN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       supplyOk,
  input  logic       isBoot,
  input  logic       unlockOk,
  input  logic [7:0] cmdByte,
  input  logic       arrDone,
  output ctlStrobe_t strb,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_ESETUP, S_PSETUP, S_BUSY} seqState_t;

  seqState_t state, stateNxt;
  logic wrPrev, wrNow, wrStrobe;
  logic opIsErase, dropSeen;

  assign wrNow    = !ceN && !weN;
  assign wrStrobe = wrNow && !wrPrev;
  assign busy     = (state == S_BUSY);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      S_IDLE: if (wrStrobe) begin
        case (cmdByte)
          CMD_READ_ARRAY: begin strb.modeEn = 1'b1; strb.mode = MODE_ARRAY;  end
          CMD_READ_ID:    begin strb.modeEn = 1'b1; strb.mode = MODE_IDENT;  end
          CMD_READ_STAT:  begin strb.modeEn = 1'b1; strb.mode = MODE_STATUS; end
          CMD_CLEAR_STAT: strb.clrErr = 1'b1;
          CMD_ERASE_SET: begin
            strb.modeEn = 1'b1; strb.mode = MODE_STATUS; stateNxt = S_ESETUP;
          end
          CMD_PROG_SET_A, CMD_PROG_SET_B: begin
            strb.modeEn = 1'b1; strb.mode = MODE_STATUS; stateNxt = S_PSETUP;
          end
          default: ;
        endcase
      end
      S_ESETUP, S_PSETUP: if (wrStrobe) begin
        strb.modeEn = 1'b1;
        strb.mode   = MODE_STATUS;
        stateNxt    = S_IDLE;
        if (state == S_ESETUP && cmdByte != CMD_ERASE_GO) begin
          strb.failErase = 1'b1;
          strb.failProg  = 1'b1;
        end else if (!supplyOk) begin
          strb.flagSupply = 1'b1;
          strb.failErase  = (state == S_ESETUP);
          strb.failProg   = (state == S_PSETUP);
        end else if (isBoot && !unlockOk) begin
          strb.flagLock  = 1'b1;
          strb.failErase = (state == S_ESETUP);
          strb.failProg  = (state == S_PSETUP);
        end else begin
          strb.issueErase = (state == S_ESETUP);
          strb.issueProg  = (state == S_PSETUP);
          stateNxt        = S_BUSY;
        end
      end
      S_BUSY: if (arrDone) begin
        stateNxt = S_IDLE;
        if (dropSeen || !supplyOk) begin
          strb.flagSupply = 1'b1;
          strb.failErase  = opIsErase;
          strb.failProg   = !opIsErase;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rpN) begin
    if (!rpN) begin
      state     <= S_IDLE;
      wrPrev    <= 1'b0;
      opIsErase <= 1'b0;
      dropSeen  <= 1'b0;
    end else begin
      state  <= stateNxt;
      wrPrev <= wrNow;
      if (strb.issueErase || strb.issueProg) begin
        opIsErase <= strb.issueErase;
        dropSeen  <= 1'b0;
      end else if (busy && !supplyOk) begin
        dropSeen <= 1'b1;
      end
    end
  end

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rpN)
    (busy && !arrDone) |=> busy);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rpN)
    (busy && arrDone) |=> !busy);

endmodule

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rpN,
  input  ctlStrobe_t        strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              isBoot,
  output logic              arrProgReq,
  output logic              arrEraseReq,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic [BLK_W-1:0]  arrBlock
);

  localparam int unsigned FULL_SZ = 2 ** (ADDR_W - 3);
  localparam int unsigned BOOT_SZ = FULL_SZ / 8;
  localparam int unsigned PAR_SZ  = FULL_SZ / 16;
  localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(BOOT_SZ);
  localparam logic [ADDR_W-1:0] LIM_PAR1 = ADDR_W'(BOOT_SZ + PAR_SZ);
  localparam logic [ADDR_W-1:0] LIM_PAR2 = ADDR_W'(BOOT_SZ + 2 * PAR_SZ);
  localparam logic [ADDR_W-1:0] LIM_MID  = ADDR_W'(FULL_SZ);
  localparam logic [BLK_W-1:0]  LAST_IDX = BLK_W'(NUM_BLK - 1);
  localparam logic [BLK_W-1:0]  BOOT_IDX = TOP_BOOT ? LAST_IDX : '0;
  localparam logic [7:0] MFR_CODE = 8'h89;
  localparam logic [7:0] DEV_HIGH = 8'h88;
  localparam logic [7:0] DEV_LOW  = TOP_BOOT ? 8'h9C : 8'h9D;

  logic [ADDR_W-1:0] mapAddr;
  logic [BLK_W-1:0]  rawIdx, blkIdx;
  readMode_t         mode;
  logic errErase, errProg, errSupply, errLock;
  logic [7:0]        statByte;
  logic [DATA_W-1:0] identWord;

  generate
    if (TOP_BOOT) begin : g_top
      assign mapAddr = ~addr;
      assign blkIdx  = LAST_IDX - rawIdx;
    end else begin : g_bottom
      assign mapAddr = addr;
      assign blkIdx  = rawIdx;
    end
  endgenerate

  always_comb begin
    if (mapAddr < LIM_BOOT)      rawIdx = BLK_W'(0);
    else if (mapAddr < LIM_PAR1) rawIdx = BLK_W'(1);
    else if (mapAddr < LIM_PAR2) rawIdx = BLK_W'(2);
    else if (mapAddr < LIM_MID)  rawIdx = BLK_W'(3);
    else rawIdx = BLK_W'(3) + {1'b0, mapAddr[ADDR_W-1 -: 3]};
  end

  assign isBoot = (blkIdx == BOOT_IDX);

  always_comb begin
    statByte           = '0;
    statByte[ST_READY] = !busy;
    statByte[ST_EFAIL] = errErase;
    statByte[ST_PFAIL] = errProg;
    statByte[ST_VLOW]  = errSupply;
    statByte[ST_LOCK]  = errLock;
  end

  assign identWord = addr[0] ? DATA_W'({DEV_HIGH, DEV_LOW}) : DATA_W'(MFR_CODE);

  always_comb begin
    if (busy || mode == MODE_STATUS) rdData = DATA_W'(statByte);
    else if (mode == MODE_IDENT)     rdData = identWord;
    else                             rdData = arrRdData;
  end

  always_ff @(posedge clk or negedge rpN) begin
    if (!rpN) begin
      mode      <= MODE_ARRAY;
      errErase  <= 1'b0;
      errProg   <= 1'b0;
      errSupply <= 1'b0;
      errLock   <= 1'b0;
    end else begin
      if (strb.modeEn) mode <= strb.mode;
      if (strb.clrErr) begin
        errErase  <= 1'b0;
        errProg   <= 1'b0;
        errSupply <= 1'b0;
        errLock   <= 1'b0;
      end else begin
        if (strb.failErase)  errErase  <= 1'b1;
        if (strb.failProg)   errProg   <= 1'b1;
        if (strb.flagSupply) errSupply <= 1'b1;
        if (strb.flagLock)   errLock   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rpN) begin
    if (!rpN) begin
      arrProgReq  <= 1'b0;
      arrEraseReq <= 1'b0;
      arrAddr     <= '0;
      arrData     <= '0;
      arrBlock    <= '0;
    end else begin
      arrProgReq  <= strb.issueProg;
      arrEraseReq <= strb.issueErase;
      if (strb.issueProg || strb.issueErase) begin
        arrAddr  <= addr;
        arrData  <= dataIn;
        arrBlock <= blkIdx;
      end
    end
  end

  // R7
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rpN)
    $onehot0({arrProgReq, arrEraseReq}));

  // R13
  clr_err_chk: assert property (@(posedge clk) disable iff (!rpN)
    strb.clrErr |=> !(errErase || errProg || errSupply || errLock));

endmodule

// File: rtl/bootflash_cmd.sv
module bootflash_cmd
  import bfc_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rpN,
  input  logic              hvUnlock,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              wpN,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] arrRdData,
  input  logic              arrDone,
  output logic              arrProgReq,
  output logic              arrEraseReq,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic [BLK_W-1:0]  arrBlock
);

  ctlStrobe_t strb;
  logic busy, isBoot;

  bfc_ctrl u_ctrl (
    .clk      (clk),
    .rpN      (rpN),
    .ceN      (ceN),
    .weN      (weN),
    .supplyOk (supplyOk),
    .isBoot   (isBoot),
    .unlockOk (wpN || hvUnlock),
    .cmdByte  (dataIn[7:0]),
    .arrDone  (arrDone),
    .strb     (strb),
    .busy     (busy)
  );

  bfc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) u_dp (
    .clk         (clk),
    .rpN         (rpN),
    .strb        (strb),
    .busy        (busy),
    .addr        (addr),
    .dataIn      (dataIn),
    .arrRdData   (arrRdData),
    .rdData      (dataOut),
    .isBoot      (isBoot),
    .arrProgReq  (arrProgReq),
    .arrEraseReq (arrEraseReq),
    .arrAddr     (arrAddr),
    .arrData     (arrData),
    .arrBlock    (arrBlock)
  );

  assign dataOe = rpN && !ceN && !oeN && weN;

  localparam logic [BLK_W-1:0] BOOT_IDX_TOP = TOP_BOOT ? BLK_W'(NUM_BLK - 1) : '0;

  // R8
  boot_unlock_chk: assert property (@(posedge clk) disable iff (!rpN)
    ((arrProgReq || arrEraseReq) && arrBlock == BOOT_IDX_TOP) |-> $past(wpN || hvUnlock));

  // R9
  supply_req_chk: assert property (@(posedge clk) disable iff (!rpN)
    (arrProgReq || arrEraseReq) |-> $past(supplyOk));

endmodule

// File: tb/bootflash_cmd_bench.sv
module bootflash_cmd_bench;

  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rpN = 1'b0, hvUnlock = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic wpN = 1'b0, supplyOk = 1'b1, arrDone = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut, arrRdData, arrData;
  logic dataOe, arrProgReq, arrEraseReq;
  logic [AW-1:0] arrAddr;
  logic [3:0] arrBlock;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign arrRdData = addr[15:0] ^ 16'h5A3C;

  bootflash_cmd u_bootflash_cmd (
    .clk(clk), .rpN(rpN), .hvUnlock(hvUnlock), .ceN(ceN), .oeN(oeN), .weN(weN),
    .wpN(wpN), .supplyOk(supplyOk), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .arrRdData(arrRdData), .arrDone(arrDone),
    .arrProgReq(arrProgReq), .arrEraseReq(arrEraseReq), .arrAddr(arrAddr),
    .arrData(arrData), .arrBlock(arrBlock)
  );

  // {write addr, write byte, read addr, expected read}
  localparam int NV = 8;
  localparam logic [61:0] VEC [NV] = '{
    {19'h00000, 8'hFF, 19'h00123, 16'h5B1F},
    {19'h00000, 8'h90, 19'h00000, 16'h0089},
    {19'h00000, 8'h00, 19'h00001, 16'h889C},
    {19'h00000, 8'h70, 19'h00155, 16'h0080},
    {19'h00000, 8'hFF, 19'h7FFFF, 16'hA5C3},
    {19'h00000, 8'h00, 19'h40000, 16'h5A3C},
    {19'h00000, 8'h90, 19'h00002, 16'h0089},
    {19'h00000, 8'h50, 19'h00003, 16'h889C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    #2;
    d = dataOut;
    @(negedge clk);
    oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic pulseDone();
    @(negedge clk); arrDone = 1'b1;
    @(negedge clk); arrDone = 1'b0;
  endtask

  task automatic expRead(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    logic [DW-1:0] v;
    busRead(a, v);
    chk(req, 32'(v), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    // R1 reset state: outputs off while held
    repeat (3) @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; #2;
    chk("R1 oe in reset", 32'(dataOe), 32'd0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk); rpN = 1'b1;
    // R2 enable gating
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b0; #2;
    chk("R2 oe with weN low", 32'(dataOe), 32'd0);
    weN = 1'b1; oeN = 1'b1; ceN = 1'b1;
    expRead("R1 array after reset", 19'h00010, 16'h5A2C);

    // R3 R4 R5 R13 table walk
    for (int i = 0; i < NV; i++) begin
      busWrite(VEC[i][61:43], {8'h00, VEC[i][42:35]});
      expRead($sformatf("R3/R4/R13 vector %0d", i), VEC[i][34:16], VEC[i][15:0]);
    end

    // R6 R11 R12 R14 erase of a main block with wpN low
    busWrite(19'h12345, 16'h0020);
    expRead("R14 setup reads status", 19'h0, 16'h0080);
    busWrite(19'h12345, 16'h00D0);
    chk("R6 erase request", 32'({arrEraseReq, arrProgReq}), 32'b10);
    chk("R12 block of 12345h", 32'(arrBlock), 32'd1);
    expRead("R5 busy status", 19'h0, 16'h0000);
    busWrite(19'h0, 16'h00FF);
    expRead("R11 write ignored while busy", 19'h0, 16'h0000);
    pulseDone();
    expRead("R14 status after done", 19'h00123, 16'h0080);
    busWrite(19'h0, 16'h00FF);
    expRead("R14 array after FF", 19'h12345, 16'h7979);

    // R6 bad confirm
    busWrite(19'h0, 16'h0020);
    busWrite(19'h0, 16'h00FF);
    chk("R6 no erase on bad confirm", 32'(arrEraseReq), 32'd0);
    expRead("R6 sequence error bits", 19'h0, 16'h00B0);
    busWrite(19'h0, 16'h0050);
    expRead("R13 clear", 19'h0, 16'h0080);

    // R8 boot locked
    busWrite(19'h7E000, 16'h0020);
    busWrite(19'h7E000, 16'h00D0);
    chk("R8 locked boot no request", 32'(arrEraseReq), 32'd0);
    expRead("R8 lock bits", 19'h0, 16'h00A2);
    busWrite(19'h0, 16'h0050);

    // R8 boot unlocked by wpN
    wpN = 1'b1;
    busWrite(19'h7E000, 16'h0020);
    busWrite(19'h7E000, 16'h00D0);
    chk("R8 wp unlock erase", 32'({arrEraseReq, arrBlock}), 32'h1A);
    pulseDone();
    wpN = 1'b0;
    expRead("R8 clean status", 19'h0, 16'h0080);

    // R7 R8 boot program via hvUnlock
    hvUnlock = 1'b1;
    busWrite(19'h7F001, 16'h0040);
    busWrite(19'h7F001, 16'hBEEF);
    chk("R7 prog request", 32'({arrProgReq, arrEraseReq}), 32'b10);
    chk("R7 prog addr", 32'(arrAddr), 32'h7F001);
    chk("R7 prog data", 32'(arrData), 32'hBEEF);
    chk("R8 hv unlock block", 32'(arrBlock), 32'd10);
    pulseDone();
    hvUnlock = 1'b0;
    @(negedge clk); #2;
    chk("R7 single-cycle request", 32'(arrProgReq), 32'd0);

    // R12 parameter and partial main blocks
    busWrite(19'h7C800, 16'h0010);
    busWrite(19'h7C800, 16'h1234);
    chk("R12 param block", 32'(arrBlock), 32'd8);
    pulseDone();
    busWrite(19'h70000, 16'h0010);
    busWrite(19'h70000, 16'h0F0F);
    chk("R12 partial main block", 32'(arrBlock), 32'd7);
    pulseDone();

    // R9 supply low at confirm
    supplyOk = 1'b0;
    busWrite(19'h00100, 16'h0010);
    busWrite(19'h00100, 16'h5555);
    chk("R9 no request", 32'(arrProgReq), 32'd0);
    expRead("R9 supply bits", 19'h0, 16'h0098);
    supplyOk = 1'b1;
    busWrite(19'h0, 16'h0050);

    // R10 supply drop during busy
    busWrite(19'h20000, 16'h0020);
    busWrite(19'h20000, 16'h00D0);
    chk("R10 erase started", 32'(arrEraseReq), 32'd1);
    @(negedge clk); supplyOk = 1'b0;
    @(negedge clk); supplyOk = 1'b1;
    pulseDone();
    expRead("R10 drop bits", 19'h0, 16'h00A8);
    busWrite(19'h0, 16'h0050);

    // R1 reset during busy; writes ignored while held
    busWrite(19'h30000, 16'h0020);
    busWrite(19'h30000, 16'h00D0);
    @(negedge clk); rpN = 1'b0;
    ceN = 1'b0; oeN = 1'b0; #2;
    chk("R1 oe off in reset", 32'(dataOe), 32'd0);
    oeN = 1'b1;
    busWrite(19'h0, 16'h0090);
    @(negedge clk); rpN = 1'b1;
    expRead("R1 array mode after reset", 19'h00005, 16'h5A39);
    busWrite(19'h0, 16'h0070);
    expRead("R1 status cleared and ready", 19'h0, 16'h0080);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule